// File: doc/BRIEF.md
# Bus wait-state generator

This block sets the stall timing for a CPU memory bus that is divided into sixteen address regions. On each access request it takes the target region, whether the access is 16 or 32 bits wide, whether it is sequential, and whether it is an instruction fetch. From these it computes a wait count. It holds the requester in a stall for that many cycles and then raises ready for one cycle. The wait count for the access in progress is also available on an output.

Software tunes the cartridge timing through a 16-bit control word. Three cartridge windows each take up two adjacent regions. Each window has its own non-sequential code and its own sequential code, and each window has a different slow sequential cost. The save-RAM regions have their own code. Costs for 32-bit accesses are derived from the 16-bit sequential cost, counted as two halfword transfers. A prefetch-enable bit removes the waits on instruction fetches from the three windows. A burst is a non-sequential access followed directly by sequential ones, and its total length follows from the per-access costs.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is held and after its release, `ready`, `stall` and `wait_cycles` are all 0 until the first request.
- R2: A request accepted at a clock edge with computed cost W drives `wait_cycles` to W from the next cycle onward. `stall` is high for W cycles, and `ready` is high in exactly the cycle W+1 cycles after the accepting edge.
- R3: A request is accepted only when the block is idle or in its ready cycle. A request raised while `stall` is high is ignored. If `req` is low in the ready cycle, the block returns to idle.
- R4: Costs before any control write, given as 16-bit N/S then 32-bit N/S, are: region 2 is 2/2 and 5/5. Regions 8 and 9 are 4/2 and 7/5. Regions 10 and 11 are 4/4 and 9/9. Regions 12 and 13 are 4/8 and 13/17. Region 14 is 4/4 and 9/9. Every other region costs 0.
- R5: After a control write, non-sequential 16-bit costs for the windows use codes 0,1,2,3, which give 4,3,2,8. Window 0 (regions 8-9) reads bits 3:2, window 1 (regions 10-11) reads bits 6:5, and window 2 (regions 12-13) reads bits 9:8.
- R6: After a control write, the sequential 16-bit cost of a window is 1 when its bit is set. When the bit is clear the cost is 2, 4 or 8 for windows 0, 1 and 2, and those windows read bits 4, 7 and 10.
- R7: After a control write, both the sequential and the non-sequential 32-bit cost of a window equal 2×S16+1.
- R8: After a control write, regions 14 and 15 take their 16-bit cost from bits 1:0 through the 4,3,2,8 map, and their 32-bit cost is 2×that+1. Region 15 costs 0 until the first write.
- R9: With bit 14 set, instruction fetches (`ifetch`=1) to regions 8-13 cost 0. Data accesses to those regions keep their normal cost, and fetches to other regions are unaffected.
- R10: A control write applies to requests accepted at later edges. A request accepted at the same edge as the write uses the old setting. A write during a stall leaves that access's wait count and timing unchanged.
- R11: A burst of n back-to-back 32-bit accesses, with the first non-sequential and the rest sequential, lasts (1+N32)+(n−1)×(1+S32) cycles from the first accepting edge to the final ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word |
| req | input | 1 | Access request |
| region | input | 4 | Target region of the access |
| wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| seq | input | 1 | 1 = sequential access |
| ifetch | input | 1 | 1 = instruction fetch |
| ready | output | 1 | Access completes this cycle |
| stall | output | 1 | Requester must wait this cycle |
| wait_cycles | output | 5 | Wait count of the current access |

## Verification
The assertions assume reset is applied before the first clock. They also assume that the request attributes (`region`, `wide`, `seq`, `ifetch`) only matter in the cycle a request is accepted, so they may change freely at any other time. The bench drives every input on the falling clock edge. It keeps `req` high during stalls only on purpose, to exercise the ignore rule, and it drops `req` in a ready cycle whenever a return to idle is intended. Control writes are issued as one-cycle strobes, some of them in the same cycle as a request and some in the middle of a stall.

// File: rtl/bus_wait_gen.sv
`timescale 1ns/1ps
module bus_wait_gen #(
  parameter int WAIT_W = 5,
  parameter int RGN_W  = 4,
  parameter int CTRL_W = 16,
  parameter int PF_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              req,
  input  logic [RGN_W-1:0]  region,
  input  logic              wide,
  input  logic              seq,
  input  logic              ifetch,
  output logic              ready,
  output logic              stall,
  output logic [WAIT_W-1:0] wait_cycles
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [CTRL_W-1:0] cfg_q;
  logic              cfg_set;
  logic              busy;
  logic [WAIT_W-1:0] cnt, wait_q, w_now;
  logic [WAIT_W-1:0] n16, s16, n32, s32, s_slow, t_sram;
  logic [1:0]        ncode;
  logic              sbit, pf_zero, accept;

  function automatic logic [WAIT_W-1:0] code_map(input logic [1:0] c);
    case (c)
      2'd0:    return WAIT_W'(4);
      2'd1:    return WAIT_W'(3);
      2'd2:    return WAIT_W'(2);
      default: return WAIT_W'(8);
    endcase
  endfunction

  always_comb begin
    n16 = '0; s16 = '0; n32 = '0; s32 = '0;
    pf_zero = 1'b0;
    ncode = 2'd0; sbit = 1'b0;
    s_slow = WAIT_W'(2) << region[2:1];
    t_sram = cfg_set ? code_map(cfg_q[1:0]) : WAIT_W'(4);
    case (region[2:1])
      2'd0:    begin ncode = cfg_q[3:2]; sbit = cfg_q[4];  end
      2'd1:    begin ncode = cfg_q[6:5]; sbit = cfg_q[7];  end
      default: begin ncode = cfg_q[9:8]; sbit = cfg_q[10]; end
    endcase
    if (region == RGN_W'(2)) begin
      n16 = WAIT_W'(2); s16 = WAIT_W'(2);
      n32 = WAIT_W'(5); s32 = WAIT_W'(5);
    end else if (region[3] && region[2:1] != 2'b11) begin
      if (!cfg_set) begin
        n16 = WAIT_W'(4);
        s16 = s_slow;
        n32 = n16 + ONE + s16;
        s32 = (s16 << 1) + ONE;
      end else begin
        n16 = code_map(ncode);
        s16 = sbit ? ONE : s_slow;
        s32 = (s16 << 1) + ONE;
        n32 = s32;
      end
      pf_zero = cfg_set && cfg_q[PF_BIT] && ifetch;
    end else if (region[3] && (!region[0] || cfg_set)) begin
      n16 = t_sram; s16 = t_sram;
      n32 = (t_sram << 1) + ONE;
      s32 = n32;
    end
  end

  assign w_now  = pf_zero ? '0 : (seq ? (wide ? s32 : s16) : (wide ? n32 : n16));
  assign ready  = busy && (cnt == '0);
  assign stall  = busy && (cnt != '0);
  assign accept = req && (!busy || ready);
  assign wait_cycles = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cfg_set <= 1'b0;
    end else if (cfg_we) begin
      cfg_q   <= cfg_wdata;
      cfg_set <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      wait_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= w_now;
      wait_q <= w_now;
    end else if (ready) begin
      busy   <= 1'b0;
    end else if (busy) begin
      cnt    <= cnt - ONE;
    end
  end
endmodule

// File: rtl/bus_wait_gen_chk.sv
`timescale 1ns/1ps
module bus_wait_gen_chk #(
  parameter int WAIT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ready,
  input logic              stall,
  input logic [WAIT_W-1:0] wait_cycles
);
  logic          idle, acc;
  logic [WAIT_W:0] run;

  assign idle = !ready && !stall;
  assign acc  = req && (ready || idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (acc)   run <= '0;
    else if (stall) run <= run + 1'b1;
  end

  AST_READY_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ready && stall)); // R2
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (run == {1'b0, wait_cycles})); // R2
  AST_STALL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (stall || ready)); // R2
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> (ready == (wait_cycles == '0))); // R2
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(wait_cycles)); // R10
  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ready && !req) |=> idle); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req && !stall) |=> !idle); // R3
  AST_COST_CAP: assert property (@(posedge clk) disable iff (!rst_n) wait_cycles <= WAIT_W'(17)); // R4
endmodule

bind bus_wait_gen bus_wait_gen_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .stall(stall), .wait_cycles(wait_cycles)
);

// File: tb/bus_wait_gen_tb.sv
`timescale 1ns/1ps
module bus_wait_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic req = 1'b0, wide = 1'b0, seq = 1'b0, ifetch = 1'b0;
  logic [3:0] region = '0;
  logic ready, stall;
  logic [4:0] wait_cycles;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [15:0] m_cfg = '0;
  bit m_set = 0;

  always #2 clk = ~clk;

  bus_wait_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .region(region), .wide(wide), .seq(seq), .ifetch(ifetch),
    .ready(ready), .stall(stall), .wait_cycles(wait_cycles)
  );

  function automatic int model(int r, bit w, bit s, bit f);
    int ntab[4] = '{4, 3, 2, 8};
    int k, n16, s16, n32, s32, t;
    if (r == 2) return w ? 5 : 2;
    if (r >= 8 && r <= 13) begin
      k = (r - 8) / 2;
      if (!m_set) begin
        n16 = 4; s16 = 2 * (1 << k); n32 = n16 + 1 + s16; s32 = 2 * s16 + 1;
      end else begin
        n16 = ntab[(m_cfg >> (2 + 3 * k)) & 3];
        s16 = m_cfg[4 + 3 * k] ? 1 : 2 * (1 << k);
        s32 = 2 * s16 + 1; n32 = s32;
      end
      if (m_set && m_cfg[14] && f) return 0;
      return s ? (w ? s32 : s16) : (w ? n32 : n16);
    end
    if (r == 14 || (r == 15 && m_set)) begin
      t = m_set ? ntab[m_cfg & 3] : 4;
      return w ? 2 * t + 1 : t;
    end
    return 0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg = v; m_set = 1;
  endtask

  task automatic run_access(int r, bit w, bit s, bit f, string tag);
    int n, e;
    e = model(r, w, s, f);
    req = 1'b1; region = r[3:0]; wide = w; seq = s; ifetch = f;
    @(posedge clk); @(negedge clk);
    req = 1'b0; n = 1;
    while (!ready && n < 40) begin @(negedge clk); n++; end
    check(n == e + 1, tag, $sformatf("ready delay r%0d w%0d s%0d f%0d", r, w, s, f), n, e + 1);
    check(wait_cycles == 5'(e), tag, $sformatf("wait r%0d w%0d s%0d f%0d", r, w, s, f), wait_cycles, e);
  endtask

  task automatic t_reset;
    check(ready == 0 && stall == 0, "R1", "ready/stall at reset", {ready, stall}, 0);
    check(wait_cycles == 0, "R1", "wait at reset", wait_cycles, 0);
  endtask

  task automatic t_defaults;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 4; c++)
        run_access(r, c[1], c[0], 1'b0, "R4");
    run_access(12, 1'b0, 1'b0, 1'b0, "R2");
    run_access(0, 1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_ignore_stall;
    int n;
    req = 1'b1; region = 4'd12; wide = 1'b0; seq = 1'b0; ifetch = 1'b0;
    @(posedge clk); @(negedge clk);
    region = 4'd2; wide = 1'b1; n = 1;
    while (!ready && n < 40) begin @(negedge clk); n++; end
    req = 1'b0;
    check(n == 5, "R3", "ready delay with req held in stall", n, 5);
    check(wait_cycles == 4, "R3", "wait unchanged by stalled req", wait_cycles, 4);
    @(negedge clk);
    check(ready == 0 && stall == 0, "R3", "idle after ready without req", {ready, stall}, 0);
  endtask

  task automatic t_cfg_timing;
    int n;
    req = 1'b1; region = 4'd8; wide = 1'b0; seq = 1'b0; ifetch = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 16'h000C;
    @(posedge clk); @(negedge clk);
    req = 1'b0; cfg_we = 1'b0; n = 1;
    while (!ready && n < 40) begin @(negedge clk); n++; end
    check(n == 5, "R10", "same-edge write uses old delay", n, 5);
    check(wait_cycles == 4, "R10", "same-edge write uses old wait", wait_cycles, 4);
    m_cfg = 16'h000C; m_set = 1;
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h0004;
    @(negedge clk);
    cfg_we = 1'b0; n = 2;
    while (!ready && n < 40) begin @(negedge clk); n++; end
    check(n == 9, "R10", "write during stall keeps delay", n, 9);
    check(wait_cycles == 8, "R10", "write during stall keeps wait", wait_cycles, 8);
    m_cfg = 16'h0004;
    run_access(8, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_codes;
    for (int c = 0; c < 4; c++) begin
      write_cfg(16'((c << 8) | (c << 5) | (c << 2) | c));
      run_access(8, 1'b0, 1'b0, 1'b0, "R5");
      run_access(11, 1'b0, 1'b0, 1'b0, "R5");
      run_access(12, 1'b0, 1'b0, 1'b0, "R5");
      run_access(14, 1'b0, 1'b0, 1'b0, "R8");
      run_access(15, 1'b1, 1'b1, 1'b0, "R8");
    end
  endtask

  task automatic t_seq_bits;
    write_cfg(16'h0000);
    for (int r = 8; r < 14; r += 2) begin
      run_access(r, 1'b0, 1'b1, 1'b0, "R6");
      run_access(r, 1'b1, 1'b1, 1'b0, "R7");
      run_access(r + 1, 1'b1, 1'b0, 1'b0, "R7");
    end
    write_cfg(16'h0490);
    for (int r = 8; r < 14; r += 2) begin
      run_access(r, 1'b0, 1'b1, 1'b0, "R6");
      run_access(r + 1, 1'b1, 1'b1, 1'b0, "R7");
      run_access(r, 1'b1, 1'b0, 1'b0, "R7");
    end
    write_cfg(16'h0080);
    run_access(10, 1'b0, 1'b1, 1'b0, "R6");
    run_access(12, 1'b0, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_prefetch;
    write_cfg(16'h4327);
    for (int r = 8; r < 16; r++)
      for (int c = 0; c < 8; c++)
        run_access(r, c[1], c[0], c[2], "R9");
    run_access(2, 1'b1, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_burst(int r, int nw, string tag);
    int total, e;
    e = (1 + model(r, 1'b1, 1'b0, 1'b0)) + (nw - 1) * (1 + model(r, 1'b1, 1'b1, 1'b0));
    total = 0;
    for (int i = 0; i < nw; i++) begin
      req = 1'b1; region = r[3:0]; wide = 1'b1; seq = (i != 0); ifetch = 1'b0;
      @(posedge clk); @(negedge clk);
      if (i == nw - 1) req = 1'b0;
      total++;
      while (!ready && total < 400) begin @(negedge clk); total++; end
    end
    check(total == e, tag, $sformatf("burst length r%0d n%0d", r, nw), total, e);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_burst(10, 4, "R11");
    t_burst(2, 3, "R11");
    t_ignore_stall();
    t_cfg_timing();
    t_codes();
    t_seq_bits();
    t_prefetch();
    t_burst(12, 5, "R11");
    t_burst(8, 1, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule